// File: doc/BRIEF.md
# Comparator Output Conditioner with Edge Interrupt

This block is the digital back end for a single analog comparator channel. The raw comparator decision arrives asynchronously. The block first brings it into the peripheral clock domain with a flop chain. It can then invert it and pass it through a glitch filter. The filter only accepts a new level after that level has been seen on a programmable number of consecutive samples. The sample strobe for the filter comes from a divider on the peripheral clock.

The conditioned level drives an edge detector whose polarity is selectable. A detected edge sets a sticky event flag, which software clears by pulsing a write-one-to-clear strobe. The interrupt request is the flag qualified by an interrupt enable. A select bit chooses whether the pin-facing output carries the unfiltered or the filtered level. While the channel enable is low, every output is held at 0 and the internal history is cleared. Re-enabling the channel therefore never produces a spurious edge.

Top module: `cmp_filter_irq`

## Requirements
- R1: The raw input passes through two flops clocked by `clk` before use. `statusOut` equals the second flop's value XOR `invertEn`, so a raw change shows at `statusOut` after the second rising edge.
- R2: For `filtCode` 0, `filtOut` follows the synchronized, conditioned level with no delay. For codes 1 to 7, `filtOut` changes only after the conditioned level has differed from it on 1, 2, 4, 8, 16, 32 or 64 consecutive sample strobes. Its register updates at the edge that takes the last of those samples, and any sample that equals the current output restarts the count.
- R3: `clkDivCode` 0, 1 and 2 give a sample strobe every 1, 2 or 4 clock cycles, counted from enable. Code 3 behaves as code 0.
- R4: `edgeSel` 1 detects rising edges of `filtOut` only. Code 2 detects falling edges only. Codes 0 and 3 detect both. `flag` rises at the clock edge after the detected change of `filtOut`.
- R5: `flag` stays set until a cycle in which `flagClr` is 1 and no new edge is detected. When an edge and `flagClr` coincide, `flag` stays 1.
- R6: `irq` is 1 exactly when `flag` and `irqEnable` are both 1.
- R7: `invertEn` complements the synchronized level before the filter and the edge detector. Inverting a steady input therefore produces an edge after the filter delay.
- R8: With `pinSelFilt` 0, `pinOut` carries the unfiltered conditioned level (equal to `statusOut`). With `pinSelFilt` 1, it carries `filtOut`.
- R9: While `enable` is 0, `statusOut`, `filtOut` and `pinOut` are 0. The synchronizer, filter count, divider and edge history are cleared. The first cycle after enable never counts as an edge.
- R10: `flag` is never set while `enable` is 0, but it keeps its value through a disabled period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpRaw | input | 1 | Asynchronous raw comparator decision |
| enable | input | 1 | Channel enable |
| invertEn | input | 1 | Complement the decision before filtering |
| filtCode | input | 3 | Filter depth code (0 = bypass) |
| clkDivCode | input | 2 | Filter sample rate divider code |
| edgeSel | input | 2 | Edge polarity code for the event flag |
| pinSelFilt | input | 1 | Pin output source: 0 unfiltered, 1 filtered |
| irqEnable | input | 1 | Interrupt request enable |
| flagClr | input | 1 | Write-one-to-clear strobe for the flag |
| statusOut | output | 1 | Synchronized conditioned level |
| filtOut | output | 1 | Filtered conditioned level |
| pinOut | output | 1 | Level for the external pin |
| flag | output | 1 | Sticky edge event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a two-flop synchronizer and a longest run of 64 samples. This brings the deepest filter setting within reach. Combined with the slowest divider, it needs 256 steady cycles before the output may move. The bench therefore mixes long quiet stretches with bursts of short glitches. Random reconfiguration also changes the divider and depth codes in the middle of a run. Short disabled intervals are included, some with inversion on, so that the re-enable path and the flag's set-versus-clear priority are exercised against the reference model.

// File: rtl/cmp_filter_pkg.sv
package cmp_filter_pkg;

  // Strobes handed from the control side to the datapath each cycle
  typedef struct packed {
    logic sampleTick;  // filter takes a sample this cycle
    logic holdClr;     // channel disabled: clear all history
  } cmpStrobe_t;

  typedef enum logic [1:0] {
    EDGE_ANY  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_RSV  = 2'd3
  } edgeMode_t;

endpackage

// File: rtl/cmp_filter_datapath.sv
module cmp_filter_datapath
  import cmp_filter_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LOG_MAX = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmpRaw,
  input  logic       invertEn,
  input  logic [2:0] filtCode,
  input  logic       pinSelFilt,
  input  cmpStrobe_t strobes,
  output logic       statusOut,
  output logic       condOut,
  output logic       pinOut
);
  localparam int RUN_W = RUN_LOG_MAX + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   condRaw;
  logic                   filtReg;
  logic [RUN_W-1:0]       runCnt;
  logic [RUN_W-1:0]       runNext;
  logic [RUN_W-1:0]       runLimit;
  logic                   bypass;

  // Synchronizer chain, cleared while the channel is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               syncQ <= '0;
    else if (strobes.holdClr) syncQ <= '0;
    else                      syncQ <= {syncQ[SYNC_STAGES-2:0], cmpRaw};
  end

  assign condRaw = !strobes.holdClr && (syncQ[SYNC_STAGES-1] ^ invertEn);
  assign bypass  = (filtCode == 3'd0);

  // Required run length: 1 << (code - 1)
  always_comb begin
    runLimit = RUN_W'(1);
    if (!bypass) runLimit = RUN_W'(1) << (filtCode - 3'd1);
  end
  assign runNext = runCnt + RUN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filtReg <= 1'b0;
      runCnt  <= '0;
    end else if (strobes.holdClr) begin
      filtReg <= 1'b0;
      runCnt  <= '0;
    end else if (bypass) begin
      filtReg <= condRaw;
      runCnt  <= '0;
    end else if (strobes.sampleTick) begin
      if (condRaw == filtReg) begin
        runCnt <= '0;
      end else if (runNext >= runLimit) begin
        filtReg <= condRaw;
        runCnt  <= '0;
      end else begin
        runCnt <= runNext;
      end
    end
  end

  assign condOut   = !strobes.holdClr && (bypass ? condRaw : filtReg);
  assign statusOut = condRaw;
  assign pinOut    = pinSelFilt ? condOut : condRaw;

  // The filter register may only move on a sample strobe
  p_filt_waits_tick_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !strobes.sampleTick && !strobes.holdClr) |=> (filtReg == $past(filtReg)));

  // A disabled channel leaves an empty synchronizer behind
  p_sync_cleared_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    strobes.holdClr |=> (syncQ == '0));

endmodule

// File: rtl/cmp_filter_ctrl.sv
module cmp_filter_ctrl
  import cmp_filter_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] clkDivCode,
  input  logic [1:0] edgeSel,
  input  logic       irqEnable,
  input  logic       flagClr,
  input  logic       condOut,
  output cmpStrobe_t strobes,
  output logic       flag,
  output logic       irq
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic             tick;
  logic             prevQ;
  logic             primedQ;
  logic             rise;
  logic             fall;
  logic             edgeHit;
  logic             edgeMatch;
  edgeMode_t        mode;

  // Divider: reserved code falls back to full rate
  always_comb begin
    unique case (clkDivCode)
      2'd1:    divLast = DIV_W'(1);
      2'd2:    divLast = DIV_W'(3);
      default: divLast = '0;
    endcase
  end
  assign tick = (divCnt >= divLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       divCnt <= '0;
    else if (!enable) divCnt <= '0;
    else if (tick)    divCnt <= '0;
    else              divCnt <= divCnt + DIV_W'(1);
  end

  assign strobes.sampleTick = enable && tick;
  assign strobes.holdClr    = !enable;

  // Edge history is only valid after one enabled cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevQ   <= 1'b0;
      primedQ <= 1'b0;
    end else if (!enable) begin
      prevQ   <= 1'b0;
      primedQ <= 1'b0;
    end else begin
      prevQ   <= condOut;
      primedQ <= 1'b1;
    end
  end

  assign mode = edgeMode_t'(edgeSel);
  assign rise = condOut && !prevQ;
  assign fall = !condOut && prevQ;

  always_comb begin
    unique case (mode)
      EDGE_RISE: edgeMatch = rise;
      EDGE_FALL: edgeMatch = fall;
      default:   edgeMatch = rise || fall;
    endcase
  end
  assign edgeHit = enable && primedQ && edgeMatch;

  // Hardware set has priority over the software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (edgeHit) flag <= 1'b1;
    else if (flagClr) flag <= 1'b0;
  end

  assign irq = flag && irqEnable;

  p_flag_sticky_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flagClr) |=> flag);

  p_clear_then_low_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (flagClr && !edgeHit) |=> !flag);

  p_no_set_when_off_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !flag) |=> !flag);

  p_quarter_rate_gap_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.sampleTick && clkDivCode == 2'd2) |=> (clkDivCode != 2'd2 || !strobes.sampleTick));

endmodule

// File: rtl/cmp_filter_irq.sv
module cmp_filter_irq
  import cmp_filter_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LOG_MAX = 6,
  parameter int DIV_W       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmpRaw,
  input  logic       enable,
  input  logic       invertEn,
  input  logic [2:0] filtCode,
  input  logic [1:0] clkDivCode,
  input  logic [1:0] edgeSel,
  input  logic       pinSelFilt,
  input  logic       irqEnable,
  input  logic       flagClr,
  output logic       statusOut,
  output logic       filtOut,
  output logic       pinOut,
  output logic       flag,
  output logic       irq
);
  cmpStrobe_t strobes;
  logic       condOut;

  cmp_filter_ctrl #(
    .DIV_W(DIV_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .clkDivCode(clkDivCode),
    .edgeSel   (edgeSel),
    .irqEnable (irqEnable),
    .flagClr   (flagClr),
    .condOut   (condOut),
    .strobes   (strobes),
    .flag      (flag),
    .irq       (irq)
  );

  cmp_filter_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .RUN_LOG_MAX(RUN_LOG_MAX)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmpRaw    (cmpRaw),
    .invertEn  (invertEn),
    .filtCode  (filtCode),
    .pinSelFilt(pinSelFilt),
    .strobes   (strobes),
    .statusOut (statusOut),
    .condOut   (condOut),
    .pinOut    (pinOut)
  );

  assign filtOut = condOut;

  // Disabled channel shows nothing at its level outputs
  p_off_outputs_low_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!statusOut && !filtOut && !pinOut));

endmodule

// File: tb/cmp_filter_irq_tb.sv
module cmp_filter_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmpRaw = 1'b0, enable = 1'b0, invertEn = 1'b0;
  logic [2:0] filtCode = '0;
  logic [1:0] clkDivCode = '0, edgeSel = '0;
  logic pinSelFilt = 1'b0, irqEnable = 1'b0, flagClr = 1'b0;
  logic statusOut, filtOut, pinOut, flag, irq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_filter_irq u_dut (
    .clk(clk), .rst_n(rst_n), .cmpRaw(cmpRaw), .enable(enable),
    .invertEn(invertEn), .filtCode(filtCode), .clkDivCode(clkDivCode),
    .edgeSel(edgeSel), .pinSelFilt(pinSelFilt), .irqEnable(irqEnable),
    .flagClr(flagClr), .statusOut(statusOut), .filtOut(filtOut),
    .pinOut(pinOut), .flag(flag), .irq(irq)
  );

  // Behavioural reference: delay queue, integer counters
  bit mq[$];
  int mPhase, mRun;
  bit mFilt, mPrev, mPrimed, mFlag;

  function automatic bit mStatus();
    return enable && (mq[0] ^ invertEn);
  endfunction

  function automatic bit mFiltered();
    if (!enable) return 1'b0;
    return (filtCode == 0) ? mStatus() : mFilt;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq = '{1'b0, 1'b0};
      mPhase = 0; mRun = 0;
      mFilt = 0; mPrev = 0; mPrimed = 0; mFlag = 0;
    end else begin
      bit cur, raw, tick, hit, r, f;
      int period, need;
      cur = mFiltered();
      raw = mStatus();
      period = (clkDivCode == 1) ? 2 : (clkDivCode == 2) ? 4 : 1;
      tick = enable && (mPhase >= period - 1);
      r = cur && !mPrev;
      f = !cur && mPrev;
      hit = enable && mPrimed &&
            ((edgeSel == 1) ? r : (edgeSel == 2) ? f : (r || f));
      if (hit) mFlag = 1;
      else if (flagClr) mFlag = 0;
      if (!enable) begin
        mq = '{1'b0, 1'b0};
        mPhase = 0; mRun = 0; mFilt = 0; mPrev = 0; mPrimed = 0;
      end else begin
        mq.push_back(cmpRaw);
        void'(mq.pop_front());
        if (filtCode == 0) begin
          mFilt = raw; mRun = 0;
        end else if (tick) begin
          need = 1 << (filtCode - 1);
          if (raw == mFilt) mRun = 0;
          else if (mRun + 1 >= need) begin mFilt = raw; mRun = 0; end
          else mRun = mRun + 1;
        end
        mPhase = tick ? 0 : mPhase + 1;
        mPrev = cur;
        mPrimed = 1;
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ef;
      ef = mFiltered();
      chk("R1 R7 R9 statusOut", statusOut, mStatus());
      chk("R2 R3 filtOut", filtOut, ef);
      chk("R8 pinOut", pinOut, pinSelFilt ? ef : mStatus());
      chk("R4 R5 R10 flag", flag, mFlag);
      chk("R6 irq", irq, mFlag && irqEnable);
    end
  end

  task automatic runSeg(int cycles, int permille, int clrOdds);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if ($urandom_range(999) < permille) cmpRaw = ~cmpRaw;
      flagClr = (clrOdds > 0) && ($urandom_range(clrOdds - 1) == 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // Reset state, R9: disabled after reset so every output is 0
    chk("R9 reset statusOut", statusOut, 1'b0);
    chk("R9 reset filtOut", filtOut, 1'b0);
    chk("R5 reset flag", flag, 1'b0);
    chk("R6 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    enable = 1'b1;
    irqEnable = 1'b1;
    // R1 R2: bypass filter, full rate, both edges
    runSeg(300, 40, 8);
    // R4: rising only, falling only, reserved polarity
    for (int e = 1; e < 4; e++) begin
      edgeSel = e[1:0];
      runSeg(300, 40, 6);
    end
    // R7: inversion with a steady input
    edgeSel = 2'd0;
    invertEn = 1'b1;
    runSeg(50, 0, 0);
    // R2 R3: each depth at each divider code, slow and glitchy input
    for (int c = 1; c < 8; c++) begin
      for (int d = 0; d < 4; d++) begin
        filtCode = c[2:0];
        clkDivCode = d[1:0];
        pinSelFilt = d[0];
        runSeg(600, 3, 40);
        runSeg(200, 300, 40);
      end
    end
    // R9 R10: disable with inversion, then re-enable
    for (int k = 0; k < 6; k++) begin
      enable = 1'b0;
      runSeg(12, 200, 0);
      enable = 1'b1;
      runSeg(150, 30, 0);
    end
    // Mixed random reconfiguration, including mid-run changes
    for (int s = 0; s < 60; s++) begin
      filtCode = 3'($urandom_range(7));
      clkDivCode = 2'($urandom_range(3));
      edgeSel = 2'($urandom_range(3));
      invertEn = 1'($urandom_range(1));
      pinSelFilt = 1'($urandom_range(1));
      irqEnable = 1'($urandom_range(1));
      enable = ($urandom_range(7) != 0);
      runSeg(300, (s % 3 == 0) ? 5 : 80, 10);
    end
    flagClr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule